// File: doc/BRIEF.md
# Transmit Sample FIFO with Refill Interrupt

This block buffers audio samples between a register write port and a serial audio transmitter. Software pushes 32-bit words into a 32-entry queue through a data register. The serializer takes words from the head of the queue through a pop request and valid handshake. Pops are served only while the start bit is set.

An interrupt line tells software when to refill the queue. A threshold status holds whenever the fill level is at or below a programmed watermark. A sticky underrun status records a pop that was requested while the queue was empty.

A flush command empties the queue at once. Its control bit then stays readable as 1 for a fixed number of cycles before it clears itself.

Top module: `tx_sample_fifo`

## Requirements
- R1: After reset the level reads 0, the control register reads 0, the status register reads 1 (threshold status set, since level 0 is at or below the reset watermark 0, and underrun clear), and `irq` is low.
- R2: Words written to address 4 are popped in write order. Each accepted write adds 1 to the level at address 3, bits [5:0]. Each served pop subtracts 1.
- R3: A full queue reports level 32. A write to address 4 while full is dropped and leaves the stored words and their order unchanged.
- R4: While start (address 0, bit 0) is 0, `pop_valid` is low, pop requests remove nothing and the underrun status is not set.
- R5: The threshold status (address 2, bit 0) is 1 exactly when the level is at or below the watermark (address 1, bits [4:0]). It follows the level and is not sticky.
- R6: A pop request while start is 1 and the queue is empty sets the underrun status (address 2, bit 1). It stays set until a write to address 0 with bit 2 at 1.
- R7: `irq` is high when (threshold status AND enable at address 1, bit 8) OR (underrun status AND enable at address 1, bit 9).
- R8: Writing address 0 with bit 1 at 1 empties the queue on the next edge. Bit 1 of address 0 then reads 1 for FLUSH_CYCLES cycles and reads 0 after that. Data writes during that window are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Write address |
| reg_wdata | input | WIDTH | Write data |
| reg_raddr | input | AW | Read address |
| reg_rdata | output | WIDTH | Read data, combinational on `reg_raddr` |
| pop_req | input | 1 | Serializer requests the head word |
| pop_valid | output | 1 | Head word available (started, not empty, not flushing) |
| pop_data | output | WIDTH | Head word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a depth of 32 and a width of 32, so it can fill the queue completely, observe level 32 and attempt an overflow write. FLUSH_CYCLES is set to 3 rather than the default 2. The flush bit must therefore stay high for a count taken from the parameter, and the bench can place a dropped data write inside the flush window and still observe two further busy cycles.

// File: rtl/tx_sample_fifo.sv
module tx_sample_fifo #(
  parameter int DEPTH        = 32,
  parameter int WIDTH        = 32,
  parameter int FLUSH_CYCLES = 2,
  parameter int AW           = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  input  logic [AW-1:0]    reg_raddr,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic             pop_req,
  output logic             pop_valid,
  output logic [WIDTH-1:0] pop_data,
  output logic             irq
);
  localparam int LW = $clog2(DEPTH);
  localparam int CW = $clog2(FLUSH_CYCLES + 1);
  localparam logic [LW:0]   FULL_LVL = (LW+1)'(DEPTH);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_CFG   = AW'(1);
  localparam logic [AW-1:0] A_STAT  = AW'(2);
  localparam logic [AW-1:0] A_LEVEL = AW'(3);
  localparam logic [AW-1:0] A_DATA  = AW'(4);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [LW-1:0]    wr_ptr, rd_ptr, thr;
  logic [LW:0]      level;
  logic [CW-1:0]    fl_cnt;
  logic             start, thr_en, urun_en, urun;

  wire ctrl_wr   = reg_wr && reg_addr == A_CTRL;
  wire cfg_wr    = reg_wr && reg_addr == A_CFG;
  wire data_wr   = reg_wr && reg_addr == A_DATA;
  wire flush_req = ctrl_wr && reg_wdata[1];
  wire flushing  = fl_cnt != '0;
  wire empty     = level == '0;
  wire full      = level == FULL_LVL;
  wire push      = data_wr && !full && !flushing && !flush_req;
  wire pop       = pop_req && pop_valid;
  wire urun_set  = pop_req && start && empty && !flushing && !flush_req;
  wire thr_stat  = level <= {1'b0, thr};

  assign pop_valid = start && !empty && !flushing;
  assign pop_data  = mem[rd_ptr];
  assign irq       = (thr_stat && thr_en) || (urun && urun_en);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      fl_cnt <= '0;
    end else if (flush_req) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      fl_cnt <= CW'(FLUSH_CYCLES);
    end else begin
      if (flushing) fl_cnt <= fl_cnt - 1'b1;
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start   <= 1'b0;
      thr     <= '0;
      thr_en  <= 1'b0;
      urun_en <= 1'b0;
      urun    <= 1'b0;
    end else begin
      if (ctrl_wr) start <= reg_wdata[0];
      if (cfg_wr) begin
        thr     <= reg_wdata[LW-1:0];
        thr_en  <= reg_wdata[8];
        urun_en <= reg_wdata[9];
      end
      if (urun_set)                      urun <= 1'b1;
      else if (ctrl_wr && reg_wdata[2])  urun <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      A_CTRL:  begin reg_rdata[0] = start; reg_rdata[1] = flushing; end
      A_CFG:   begin reg_rdata[LW-1:0] = thr; reg_rdata[8] = thr_en; reg_rdata[9] = urun_en; end
      A_STAT:  begin reg_rdata[0] = thr_stat; reg_rdata[1] = urun; end
      A_LEVEL: reg_rdata[LW:0] = level;
      default: reg_rdata = '0;
    endcase
  end

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && data_wr && !pop && !flush_req) |=> level == FULL_LVL);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (level == '0) && flushing && !pop_valid);

  // R6
  urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (urun && !(ctrl_wr && reg_wdata[2])) |=> urun);

  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !data_wr && !ctrl_wr) |=> $stable(level) && !urun_set);
endmodule

// File: tb/tx_sample_fifo_tb.sv
module tx_sample_fifo_tb;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, pop_req = 1'b0;
  logic [2:0] reg_addr = '0, reg_raddr = '0;
  logic [W-1:0] reg_wdata = '0, reg_rdata, pop_data;
  logic pop_valid, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tx_sample_fifo #(.DEPTH(32), .WIDTH(W), .FLUSH_CYCLES(3), .AW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data), .irq(irq));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic pop(output logic v, output logic [W-1:0] d);
    pop_req = 1'b1; #1; v = pop_valid; d = pop_data;
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  task automatic flush_wait();
    wr(3'd0, 32'h2);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    rd(3'd3, d); check("R1 level", d, 0);
    rd(3'd0, d); check("R1 ctrl", d, 0);
    rd(3'd2, d); check("R1 status", d, 1);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_order();
    logic [W-1:0] d; logic v;
    wr(3'd0, 1);
    wr(3'd4, 32'hA1); wr(3'd4, 32'hB2); wr(3'd4, 32'hC3);
    rd(3'd3, d); check("R2 level after 3 writes", d, 3);
    pop(v, d); check("R2 pop0 valid", v, 1); check("R2 pop0", d, 32'hA1);
    pop(v, d); check("R2 pop1", d, 32'hB2);
    pop(v, d); check("R2 pop2", d, 32'hC3);
    rd(3'd3, d); check("R2 level drained", d, 0);
  endtask

  task automatic t_start_gate();
    logic [W-1:0] d; logic v;
    wr(3'd0, 0);
    wr(3'd4, 32'h11); wr(3'd4, 32'h22);
    pop(v, d); check("R4 valid low when stopped", v, 0);
    rd(3'd3, d); check("R4 level kept", d, 2);
    rd(3'd2, d); check("R4 no underrun", d[1], 0);
    wr(3'd0, 1);
    pop(v, d); check("R4 pop after start", d, 32'h11);
    pop(v, d); check("R4 second pop", d, 32'h22);
  endtask

  task automatic t_full();
    logic [W-1:0] d; logic v; int bad;
    wr(3'd0, 0);
    for (int i = 0; i < 32; i++) wr(3'd4, 32'h1000 + i);
    rd(3'd3, d); check("R3 full level", d, 32);
    wr(3'd4, 32'hDEAD);
    rd(3'd3, d); check("R3 level after overflow write", d, 32);
    wr(3'd0, 1);
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      pop(v, d);
      if (d !== 32'h1000 + i || !v) bad++;
    end
    check("R3 stored order intact", bad, 0);
    rd(3'd3, d); check("R3 empty after drain", d, 0);
  endtask

  task automatic t_threshold();
    logic [W-1:0] d; logic v;
    wr(3'd0, 0);
    wr(3'd1, 32'h104);
    rd(3'd2, d); check("R5 at level 0 below wm", d[0], 1);
    check("R7 irq thr", irq, 1);
    for (int i = 0; i < 5; i++) wr(3'd4, i);
    rd(3'd2, d); check("R5 above wm", d[0], 0);
    check("R7 irq low", irq, 0);
    wr(3'd0, 1);
    pop(v, d);
    rd(3'd2, d); check("R5 back at wm", d[0], 1);
    wr(3'd1, 32'h004);
    check("R7 irq masked", irq, 0);
    flush_wait();
  endtask

  task automatic t_underrun();
    logic [W-1:0] d; logic v;
    wr(3'd1, 32'h200);
    wr(3'd0, 1);
    pop(v, d); check("R6 valid low on empty", v, 0);
    rd(3'd2, d); check("R6 underrun set", d[1], 1);
    check("R7 irq underrun", irq, 1);
    wr(3'd0, 0);
    wr(3'd4, 32'h99);
    rd(3'd2, d); check("R6 sticky", d[1], 1);
    wr(3'd0, 32'h4);
    rd(3'd2, d); check("R6 cleared", d[1], 0);
    check("R7 irq after clear", irq, 0);
    flush_wait();
  endtask

  task automatic t_flush();
    logic [W-1:0] d; logic v;
    wr(3'd1, 0);
    wr(3'd0, 0);
    wr(3'd4, 1); wr(3'd4, 2); wr(3'd4, 3);
    wr(3'd0, 32'h2);
    rd(3'd0, d); check("R8 busy after write", d[1], 1);
    rd(3'd3, d); check("R8 level zero", d, 0);
    wr(3'd4, 32'h55);
    rd(3'd0, d); check("R8 busy cycle 2", d[1], 1);
    rd(3'd3, d); check("R8 write dropped", d, 0);
    @(negedge clk);
    rd(3'd0, d); check("R8 busy cycle 3", d[1], 1);
    @(negedge clk);
    rd(3'd0, d); check("R8 self-cleared", d[1], 0);
    wr(3'd4, 32'h77);
    wr(3'd0, 1);
    pop(v, d); check("R8 new data after flush", d, 32'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_start_gate();
    t_full();
    t_threshold();
    t_underrun();
    t_flush();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule